// File: doc/BRIEF.md
# DDR SDRAM Command Decoder with Bank Tracking

This block sits on the control side of a DDR SDRAM device model or a memory-controller monitor. On every rising clock edge it samples chip select, the three command strobes (RAS, CAS, WE), clock enable, a two-bit bank address and a 12-bit address bus. It turns them into one decoded command per cycle, together with the target bank, the row or column and the A10 option flags.

The block keeps, for each of the four banks, whether the bank is idle or holds an open row, and which row that is. A command that makes no sense in the current bank state is flagged as illegal and leaves every bank as it was. Clock enable can suspend command decoding for one cycle. Together with the refresh encoding, it also enters and leaves self refresh.

All decoded outputs are registered. A command sampled at one rising edge appears on the outputs right after that edge, and the bank state it causes is visible at the same time.

Top module: `ddr_cmd_decoder`

## Requirements
- R1: When chip select (`cs_n`) is sampled high, the decoded command is NOP (code 0), whatever levels RAS, CAS and WE have.
- R2: With `cs_n` low, the strobe levels {ras_n,cas_n,we_n} decode as follows: 111 gives NOP (0), 011 gives ACT (1), 101 gives RD (2), 100 gives WR (3), 010 gives PRE (4), 001 with `cke` high gives REF (5), and 001 with `cke` low gives SREF (6). Every other combination gives OTHER (7). The decoded command is presented on `cmd` after the sampling edge.
- R3: A legal ACT reports the bank on `cmd_bank` and the full address on `cmd_addr`. It sets that bank's bit in `bank_open` and stores the row in its 12-bit slice of `open_rows`, where bank b occupies bits [12b+11:12b].
- R4: RD and WR to an open bank report the column as `addr[8:0]`, zero-extended, on `cmd_addr`, whatever the other address bits are. `cmd_ap` shows the level of `addr[10]`.
- R5: A RD or WR with `addr[10]` high closes the bank exactly BURST_CYC edges after the command edge (4 by default). Until then, a RD, WR or ACT to that bank is illegal.
- R6: PRE with `addr[10]` low closes only the addressed bank. PRE with `addr[10]` high closes all four banks and raises `cmd_all`. A closed bank reads back a row of 0.
- R7: REF is legal only when all banks are idle, and all banks remain idle after it.
- R8: An ACT to an open bank, a RD or WR to an idle bank, and a REF or SREF while any bank is open raise `illegal` for that command's cycle only, and leave `bank_open` and `open_rows` unchanged.
- R9: OTHER encodings change no bank state and never raise `illegal`.
- R10: When `cke` is sampled low, the command sampled at the next edge is ignored and decodes as NOP.
- R11: A legal SREF sets `self_ref`. While `self_ref` is high, every command decodes as NOP. `self_ref` clears at the first edge where `cke` is sampled high, and commands are accepted again from the following edge.
- R12: During and after reset, `cmd` is NOP, `illegal` is low, all banks are idle, every row slice reads 0 and `self_ref` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| cke | input | 1 | Clock enable |
| ba | input | 2 | Bank address |
| addr | input | 12 | Row / column address, bit 10 carries the precharge option |
| cmd | output | 3 | Decoded command code |
| cmd_bank | output | 2 | Target bank of the decoded command |
| cmd_addr | output | 12 | Row for ACT, column for RD/WR, else 0 |
| cmd_ap | output | 1 | Auto-precharge requested on RD/WR |
| cmd_all | output | 1 | Precharge-all requested on PRE |
| illegal | output | 1 | Decoded command was illegal for the bank state |
| bank_open | output | 4 | One bit per bank, high while a row is open |
| open_rows | output | 48 | Open row of each bank, 12 bits per bank |
| self_ref | output | 1 | Self refresh active |

## Verification
The bench re-activates an open bank, reads an idle bank and refreshes while a row is open. A design that let any of these through would show a changed row or a dropped `bank_open` bit.

It times the auto-precharge closure edge by edge. A counter that is off by one closes the bank a cycle early or late, and a missing busy check accepts a second read inside the window.

It drops `cke` for a single cycle with an ACT behind it. A decoder that ignores the suspend would open a bank. It then walks through self-refresh entry and exit, where an exit one edge late swallows the first ACT.

Deselect with all strobes low and the mode-register encoding must both leave the banks alone. Otherwise a spurious REF or OTHER would change state.

// File: rtl/ddr_cmd_decoder.sv
module ddr_cmd_decoder #(
  parameter int ROW_W     = 12,
  parameter int COL_W     = 9,
  parameter int BA_W      = 2,
  parameter int AP_BIT    = 10,
  parameter int BURST_CYC = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cs_n,
  input  logic                      ras_n,
  input  logic                      cas_n,
  input  logic                      we_n,
  input  logic                      cke,
  input  logic [BA_W-1:0]           ba,
  input  logic [ROW_W-1:0]          addr,
  output logic [2:0]                cmd,
  output logic [BA_W-1:0]           cmd_bank,
  output logic [ROW_W-1:0]          cmd_addr,
  output logic                      cmd_ap,
  output logic                      cmd_all,
  output logic                      illegal,
  output logic [(1<<BA_W)-1:0]      bank_open,
  output logic [(1<<BA_W)*ROW_W-1:0] open_rows,
  output logic                      self_ref
);
  localparam int NB = 1 << BA_W;
  localparam int CW = $clog2(BURST_CYC + 1);

  localparam logic [2:0] C_NOP = 3'd0, C_ACT = 3'd1, C_RD = 3'd2, C_WR = 3'd3,
                         C_PRE = 3'd4, C_REF = 3'd5, C_SRF = 3'd6, C_OTH = 3'd7;

  logic [ROW_W-1:0] row_q [NB];
  logic [CW-1:0]    ap_cnt [NB];
  logic             cke_q;
  logic [2:0]       dec;
  logic             bad;

  wire run    = cke_q && !self_ref;
  wire rdwr   = (dec == C_RD) || (dec == C_WR);
  wire a10    = addr[AP_BIT];
  wire t_open = bank_open[ba];
  wire t_busy = ap_cnt[ba] != '0;

  always_comb begin
    dec = C_NOP;
    if (!cs_n && run) begin
      case ({ras_n, cas_n, we_n})
        3'b111:  dec = C_NOP;
        3'b011:  dec = C_ACT;
        3'b101:  dec = C_RD;
        3'b100:  dec = C_WR;
        3'b010:  dec = C_PRE;
        3'b001:  dec = cke ? C_REF : C_SRF;
        default: dec = C_OTH;
      endcase
    end
  end

  assign bad = ((dec == C_ACT) && (t_open || t_busy)) ||
               (rdwr && (!t_open || t_busy)) ||
               (((dec == C_REF) || (dec == C_SRF)) && (|bank_open));

  generate
    for (genvar g = 0; g < NB; g++) begin : g_rows
      assign open_rows[g*ROW_W +: ROW_W] = row_q[g];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cke_q     <= 1'b1;
      self_ref  <= 1'b0;
      cmd       <= C_NOP;
      cmd_bank  <= '0;
      cmd_addr  <= '0;
      cmd_ap    <= 1'b0;
      cmd_all   <= 1'b0;
      illegal   <= 1'b0;
      bank_open <= '0;
      for (int b = 0; b < NB; b++) begin
        row_q[b]  <= '0;
        ap_cnt[b] <= '0;
      end
    end else begin
      cke_q    <= cke;
      cmd      <= dec;
      illegal  <= bad;
      cmd_bank <= (dec inside {C_ACT, C_RD, C_WR, C_PRE}) ? ba : '0;
      cmd_addr <= (dec == C_ACT) ? addr :
                  rdwr ? ROW_W'(addr[COL_W-1:0]) : '0;
      cmd_ap   <= rdwr && a10;
      cmd_all  <= (dec == C_PRE) && a10;
      if (self_ref && cke) self_ref <= 1'b0;

      for (int b = 0; b < NB; b++) begin
        if (ap_cnt[b] != '0) begin
          ap_cnt[b] <= ap_cnt[b] - 1'b1;
          if (ap_cnt[b] == CW'(1)) begin
            bank_open[b] <= 1'b0;
            row_q[b]     <= '0;
          end
        end
      end

      if (!bad) begin
        case (dec)
          C_ACT: begin
            bank_open[ba] <= 1'b1;
            row_q[ba]     <= addr;
          end
          C_RD, C_WR: if (a10) ap_cnt[ba] <= CW'(BURST_CYC);
          C_PRE: begin
            for (int b = 0; b < NB; b++) begin
              if (a10 || (BA_W'(b) == ba)) begin
                bank_open[b] <= 1'b0;
                row_q[b]     <= '0;
                ap_cnt[b]    <= '0;
              end
            end
          end
          C_SRF: self_ref <= 1'b1;
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/ddr_cmd_decoder_chk.sv
module ddr_cmd_decoder_chk #(
  parameter int ROW_W = 12,
  parameter int BA_W  = 2
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       cs_n,
  input logic [2:0]                 cmd,
  input logic [BA_W-1:0]            cmd_bank,
  input logic [ROW_W-1:0]           cmd_addr,
  input logic                       cmd_all,
  input logic                       illegal,
  input logic [(1<<BA_W)-1:0]       bank_open,
  input logic [(1<<BA_W)*ROW_W-1:0] open_rows,
  input logic                       self_ref
);
  AST_DESELECT_NOP: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cs_n) |-> cmd == 3'd0); // R1

  AST_ACT_RECORDS_ROW: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == 3'd1 && !illegal) |-> (bank_open[cmd_bank] &&
      open_rows[cmd_bank*ROW_W +: ROW_W] == cmd_addr)); // R3

  AST_PREA_ALL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == 3'd4 && cmd_all) |-> bank_open == '0); // R6

  AST_REF_ALL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == 3'd5 && !illegal) |-> bank_open == '0); // R7

  AST_ILLEGAL_ROWS_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (illegal && cmd == 3'd1) |-> $stable(open_rows[cmd_bank*ROW_W +: ROW_W])); // R8

  AST_OTHER_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == 3'd7 || cmd == 3'd0 || cmd == 3'd4) |-> !illegal); // R9

  AST_SELF_REF_NOP: assert property (@(posedge clk) disable iff (!rst_n)
    self_ref |=> cmd == 3'd0); // R11
endmodule

bind ddr_cmd_decoder ddr_cmd_decoder_chk #(.ROW_W(ROW_W), .BA_W(BA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .cmd(cmd), .cmd_bank(cmd_bank),
  .cmd_addr(cmd_addr), .cmd_all(cmd_all), .illegal(illegal),
  .bank_open(bank_open), .open_rows(open_rows), .self_ref(self_ref));

// File: tb/ddr_cmd_decoder_tb.sv
module ddr_cmd_decoder_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, cke = 1'b1;
  logic [1:0]  ba = '0;
  logic [11:0] addr = '0;
  logic [2:0]  cmd;
  logic [1:0]  cmd_bank;
  logic [11:0] cmd_addr;
  logic        cmd_ap, cmd_all, illegal, self_ref;
  logic [3:0]  bank_open;
  logic [47:0] open_rows;
  int errors = 0, checks = 0;
  bit done = 1'b0;

  ddr_cmd_decoder u_dut (.*);

  always #10 clk = ~clk;

  task automatic chk(string tag, logic [47:0] act, logic [47:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic send(logic c, logic [2:0] rcw, logic [1:0] b, logic [11:0] a, logic k);
    cs_n = c; {ras_n, cas_n, we_n} = rcw; ba = b; addr = a; cke = k;
    @(negedge clk);
    cs_n = 1'b1; {ras_n, cas_n, we_n} = 3'b111; cke = 1'b1;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  function automatic logic [11:0] row_of(int b);
    return open_rows[b*12 +: 12];
  endfunction

  task automatic t_reset();
    chk("R12 cmd", cmd, 0); chk("R12 open", bank_open, 0);
    chk("R12 rows", open_rows, 0); chk("R12 illegal", illegal, 0);
    chk("R12 self_ref", self_ref, 0);
  endtask

  task automatic t_deselect();
    send(1'b1, 3'b000, 2'd1, 12'h123, 1'b1);
    chk("R1 deselect", cmd, 0); chk("R1 open", bank_open, 0);
    send(1'b0, 3'b111, 2'd0, 12'h0, 1'b1);
    chk("R2 nop", cmd, 0);
  endtask

  task automatic t_act_rw();
    send(1'b0, 3'b011, 2'd1, 12'hABC, 1'b1);
    chk("R3 cmd", cmd, 1); chk("R3 bank", cmd_bank, 1); chk("R3 addr", cmd_addr, 12'hABC);
    chk("R3 open", bank_open, 4'b0010); chk("R3 row", row_of(1), 12'hABC);
    send(1'b0, 3'b011, 2'd1, 12'h111, 1'b1);
    chk("R8 act open ill", illegal, 1); chk("R8 row kept", row_of(1), 12'hABC);
    send(1'b0, 3'b101, 2'd2, 12'h0, 1'b1);
    chk("R8 rd idle ill", illegal, 1); chk("R8 open kept", bank_open, 4'b0010);
    send(1'b0, 3'b100, 2'd1, 12'h3FF, 1'b1);
    chk("R4 wr cmd", cmd, 3); chk("R4 col", cmd_addr, 12'h1FF);
    chk("R4 ap", cmd_ap, 0); chk("R8 one cycle", illegal, 0);
    send(1'b0, 3'b001, 2'd0, 12'h0, 1'b1);
    chk("R7 ref ill", illegal, 1); chk("R7 open kept", bank_open, 4'b0010);
    send(1'b0, 3'b000, 2'd0, 12'h0, 1'b1);
    chk("R9 other", cmd, 7); chk("R9 legal", illegal, 0); chk("R9 open", bank_open, 4'b0010);
    send(1'b0, 3'b010, 2'd1, 12'h0, 1'b1);
    chk("R6 pre", cmd, 4); chk("R6 closed", bank_open, 0); chk("R6 row0", row_of(1), 0);
  endtask

  task automatic t_prea();
    send(1'b0, 3'b011, 2'd0, 12'h055, 1'b1);
    send(1'b0, 3'b011, 2'd3, 12'hF0F, 1'b1);
    chk("R3 two open", bank_open, 4'b1001); chk("R3 row3", row_of(3), 12'hF0F);
    send(1'b0, 3'b010, 2'd0, 12'h400, 1'b1);
    chk("R6 all flag", cmd_all, 1); chk("R6 all closed", bank_open, 0);
  endtask

  task automatic t_autopre();
    send(1'b0, 3'b011, 2'd2, 12'h005, 1'b1);
    send(1'b0, 3'b101, 2'd2, 12'h410, 1'b1);
    chk("R4 rd", cmd, 2); chk("R4 rd col", cmd_addr, 12'h010); chk("R4 ap", cmd_ap, 1);
    chk("R5 open at cmd", bank_open[2], 1);
    send(1'b0, 3'b101, 2'd2, 12'h0, 1'b1);
    chk("R5 rd in window ill", illegal, 1);
    idle(2);
    chk("R5 open edge3", bank_open[2], 1);
    idle(1);
    chk("R5 closed edge4", bank_open[2], 0); chk("R5 row0", row_of(2), 0);
    send(1'b0, 3'b001, 2'd0, 12'h0, 1'b1);
    chk("R7 ref ok", cmd, 5); chk("R7 legal", illegal, 0); chk("R7 idle", bank_open, 0);
  endtask

  task automatic t_cke();
    send(1'b1, 3'b111, 2'd0, 12'h0, 1'b0);
    send(1'b0, 3'b011, 2'd0, 12'h077, 1'b1);
    chk("R10 suspended", cmd, 0); chk("R10 not opened", bank_open, 0);
    send(1'b0, 3'b001, 2'd0, 12'h0, 1'b0);
    chk("R11 sref", cmd, 6); chk("R11 flag", self_ref, 1);
    send(1'b0, 3'b011, 2'd0, 12'h077, 1'b0);
    chk("R11 held nop", cmd, 0); chk("R11 no open", bank_open, 0); chk("R11 still", self_ref, 1);
    send(1'b1, 3'b111, 2'd0, 12'h0, 1'b1);
    chk("R11 exit", self_ref, 0);
    send(1'b0, 3'b011, 2'd0, 12'h077, 1'b1);
    chk("R11 resumed", bank_open, 4'b0001); chk("R11 row", row_of(0), 12'h077);
    send(1'b0, 3'b001, 2'd0, 12'h0, 1'b0);
    chk("R8 sref ill", illegal, 1); chk("R8 no sref", self_ref, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_deselect();
    t_act_rw();
    t_prea();
    t_autopre();
    t_cke();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule